// File: doc/BRIEF.md
# Window Watchdog Controller

This block supervises a microcontroller with a windowed watchdog. It never sees the raw watchdog pin. A separate sampling block hands it a one-cycle trigger event, and a free-running tick sets its time base. When the reset generator releases reset, it sends a start pulse. The controller then runs an ignore window, in which triggers have no effect. Next comes a first open window that is several times the normal open length. This gives the software time to synchronise.

After the first trigger, the controller alternates between two windows. In the closed window a trigger is forbidden. In the open window a trigger is required. When a trigger arrives in the open window, a closed window starts at once. A trigger inside the closed window is a fault. An open window that expires with no trigger is also a fault. Either fault raises a one-cycle reset request to the reset generator. The controller then idles until the next start pulse.

Two static mode bits choose fast timing, slow timing (every window doubled) or watchdog off. A pair of load-current flags can also suspend the watchdog. The low flag suspends it. Only the high flag resumes it, and it resumes with a fresh ignore window and a fresh long first open window.

Top module: `win_watchdog`

## Requirements
- R1: While rst_n is low and after its release, rst_req_o is 0 until a fault occurs.
- R2: A start_i pulse in the idle state begins an ignore window of IGN_TICKS ticks. trig_i has no effect during this window.
- R3: The first open window after the ignore window lasts OPEN_TICKS*LONG_MULT ticks. If it expires with no trigger, rst_req_o pulses on the clock edge that consumes the final tick.
- R4: A trigger in any open window starts a closed window of SHUT_TICKS ticks. A trigger in the closed window requests a reset on the next edge.
- R5: An expired closed window is followed by a normal open window of OPEN_TICKS ticks. That window requests a reset if it expires with no trigger.
- R6: mode_i = 2'b01 doubles every window length. mode_i = 2'b00 and mode_i = 2'b10 use the base lengths.
- R7: mode_i = 2'b11 turns the watchdog off, and no reset is requested. Any other mode value then restarts the sequence at the ignore window.
- R8: A cycle with cur_lo_i high suspends the watchdog, and no reset is requested. The suspension persists until cur_hi_i is high, which restarts the sequence at the ignore window. cur_hi_i wins when both flags are high.
- R9: After a reset request the controller idles. It ignores triggers and ticks until the next start_i.
- R10: rst_req_o is a single-cycle pulse.
- R11: When a trigger and the final tick of a window arrive in the same cycle, the trigger decides the outcome. In an open window the result is a closed window; in a closed window the result is a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reset-release pulse from the reset generator |
| tick_i | input | 1 | Time-base strobe, one window count per pulse |
| trig_i | input | 1 | Decoded valid trigger event |
| mode_i | input | 2 | Mode bits: 00 fast, 01 slow, 10 fast, 11 off |
| cur_lo_i | input | 1 | Load current below the deactivation threshold |
| cur_hi_i | input | 1 | Load current above the activation threshold |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is a trigger that lands in exactly the cycle that carries a window's last tick. The bench makes the tick a constant strobe so that window ends fall on known cycles. It then sweeps the delay between triggers one cycle at a time across both the open-window end and the closed-window end. Suspension and the off mode are each entered mid-window and then released. This checks that the restart always goes back through the ignore window and the long first open window.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int IGN_TICKS  = 64,
  parameter int OPEN_TICKS = 64,
  parameter int SHUT_TICKS = 64,
  parameter int LONG_MULT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tick_i,
  input  logic       trig_i,
  input  logic [1:0] mode_i,
  input  logic       cur_lo_i,
  input  logic       cur_hi_i,
  output logic       rst_req_o
);
  localparam int LONG_TICKS = OPEN_TICKS * LONG_MULT;
  localparam int MAX_A = (IGN_TICKS > SHUT_TICKS) ? IGN_TICKS : SHUT_TICKS;
  localparam int MAX_T = (MAX_A > LONG_TICKS) ? MAX_A : LONG_TICKS;
  localparam int CW    = $clog2(2 * MAX_T + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_IGN, S_LONG, S_SHUT, S_OPEN, S_OFF} wd_state_t;

  wd_state_t      state;
  logic [CW-1:0]  cnt, base, lim;
  logic           susp_q;

  wire susp_d = cur_hi_i ? 1'b0 : (cur_lo_i ? 1'b1 : susp_q);
  wire run    = (mode_i != 2'b11) && !susp_d;
  wire slow   = (mode_i == 2'b01);

  always_comb begin
    case (state)
      S_IGN:   base = CW'(IGN_TICKS);
      S_LONG:  base = CW'(LONG_TICKS);
      S_SHUT:  base = CW'(SHUT_TICKS);
      default: base = CW'(OPEN_TICKS);
    endcase
  end

  assign lim = slow ? (base << 1) : base;
  wire expire = tick_i && (cnt >= lim - CW'(1));
  wire [CW-1:0] cnt_inc = tick_i ? cnt + CW'(1) : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      susp_q    <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      susp_q    <= susp_d;
      rst_req_o <= 1'b0;
      if (state == S_IDLE) begin
        if (start_i) begin
          state <= run ? S_IGN : S_OFF;
          cnt   <= '0;
        end
      end else if (!run) begin
        state <= S_OFF;
        cnt   <= '0;
      end else begin
        case (state)
          S_OFF: begin
            state <= S_IGN;
            cnt   <= '0;
          end
          S_IGN: begin
            if (expire) begin
              state <= S_LONG;
              cnt   <= '0;
            end else cnt <= cnt_inc;
          end
          S_SHUT: begin
            if (trig_i) begin
              state     <= S_IDLE;
              cnt       <= '0;
              rst_req_o <= 1'b1;
            end else if (expire) begin
              state <= S_OPEN;
              cnt   <= '0;
            end else cnt <= cnt_inc;
          end
          default: begin
            if (trig_i) begin
              state <= S_SHUT;
              cnt   <= '0;
            end else if (expire) begin
              state     <= S_IDLE;
              cnt       <= '0;
              rst_req_o <= 1'b1;
            end else cnt <= cnt_inc;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       trig_i,
  input logic [1:0] mode_i,
  input logic       cur_lo_i,
  input logic       cur_hi_i,
  input logic       susp_q,
  input logic [2:0] state,
  input logic       rst_req_o
);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_IGN = 3'd1, ST_SHUT = 3'd3, ST_OFF = 3'd5;

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_idle_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> state == ST_IDLE);

  assert_ignore_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGN && trig_i) |=> !rst_req_o);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_i) |=> (state == ST_IGN || state == ST_OFF));

  assert_off_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> !rst_req_o);

  assert_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lo_i && !cur_hi_i) |=> !rst_req_o);

  assert_pretrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUT && trig_i && mode_i != 2'b11 && !cur_lo_i && !cur_hi_i && !susp_q)
      |=> rst_req_o);
endmodule

bind win_watchdog win_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i), .mode_i(mode_i),
  .cur_lo_i(cur_lo_i), .cur_hi_i(cur_hi_i), .susp_q(susp_q), .state(state),
  .rst_req_o(rst_req_o)
);

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
  localparam int IGN = 4, OPN = 5, SHT = 3, LM = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, trig = 1'b0;
  logic lo = 1'b0, hi = 1'b0, req;
  logic [1:0] mode = 2'b00;
  int checks = 0, errors = 0, pulses = 0, cyc = 0;
  int tick_div = 2;
  bit cmp_on = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  win_watchdog #(.IGN_TICKS(IGN), .OPEN_TICKS(OPN), .SHUT_TICKS(SHT), .LONG_MULT(LM)) i_win_watchdog (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick), .trig_i(trig),
    .mode_i(mode), .cur_lo_i(lo), .cur_hi_i(hi), .rst_req_o(req));

  // behavioural reference: phase 0 idle,1 ignore,2 first open,3 closed,4 open,5 off
  int ph = 0, el = 0;
  bit msusp = 0, exp_req = 0;
  always @(posedge clk) begin
    bit sn, run, done;
    int len;
    sn  = hi ? 1'b0 : (lo ? 1'b1 : msusp);
    run = (mode != 2'b11) && !sn;
    exp_req = 0;
    if (!rst_n) begin
      ph = 0; el = 0; sn = 0;
    end else if (ph == 0) begin
      if (start) begin ph = run ? 1 : 5; el = 0; end
    end else if (!run) begin
      ph = 5; el = 0;
    end else if (ph == 5) begin
      ph = 1; el = 0;
    end else begin
      len = (ph == 1) ? IGN : (ph == 2) ? OPN * LM : (ph == 3) ? SHT : OPN;
      if (mode == 2'b01) len = len * 2;
      done = tick && (el + 1 >= len);
      if (ph == 3 && trig) begin ph = 0; exp_req = 1; end
      else if ((ph == 2 || ph == 4) && trig) begin ph = 3; el = 0; end
      else if (done && ph == 1) begin ph = 2; el = 0; end
      else if (done && ph == 3) begin ph = 4; el = 0; end
      else if (done) begin ph = 0; exp_req = 1; end
      else if (tick) el = el + 1;
    end
    msusp = sn;
  end

  always @(negedge clk) begin
    cyc++;
    tick <= (tick_div == 1) ? 1'b1 : (cyc % tick_div == 0);
    if (cmp_on) begin
      checks++;
      if (req !== exp_req) begin
        errors++;
        $display("FAIL %s cycle %0d: rst_req_o=%b expected %b", tag, cyc, req, exp_req);
      end
      if (req === 1'b1) pulses++;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired: ran %0d cycles, expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1; @(negedge clk); trig = 0;
  endtask

  task automatic check_pulses(input string t, input int expv);
    @(negedge clk);
    checks++;
    if (pulses != expv) begin
      errors++;
      $display("FAIL %s reset pulses: got %0d expected %0d", t, pulses, expv);
    end
    pulses = 0;
  endtask

  initial begin
    idle(3);
    cmp_on = 1;
    tag = "R1"; idle(3); rst_n = 1; idle(10);
    check_pulses("R1", 0);

    // R2 R3: triggers inside ignore window are dropped, long first open expires
    tag = "R2/R3"; pulse_start(); pulse_trig(); idle(2); pulse_trig();
    idle(80); check_pulses("R3", 1);

    // R4 R5: good triggers then a missed open window
    tag = "R4/R5"; pulse_start(); idle(10); pulse_trig(); idle(10); pulse_trig(); idle(10); pulse_trig();
    idle(40); check_pulses("R5", 1);

    // R4: pretrigger inside the closed window
    tag = "R4"; pulse_start(); idle(10); pulse_trig(); idle(1); pulse_trig();
    idle(5); check_pulses("R4", 1);

    // R9: idle ignores triggers
    tag = "R9"; pulse_trig(); idle(5); pulse_trig(); idle(40);
    check_pulses("R9", 0);

    // R6: slow mode and alternate fast encoding
    tag = "R6"; mode = 2'b01; pulse_start(); idle(60); check_pulses("R6 slow early", 0);
    idle(60); check_pulses("R6 slow", 1);
    mode = 2'b10; pulse_start(); idle(60); check_pulses("R6 fast alt", 1);

    // R7: watchdog off, then re-armed
    tag = "R7"; mode = 2'b00; pulse_start(); idle(10); mode = 2'b11; idle(200);
    check_pulses("R7 off", 0);
    mode = 2'b00; idle(70); check_pulses("R7 rearm", 1);

    // R8: load current suspend with hysteresis
    tag = "R8"; pulse_start(); idle(20);
    @(negedge clk); lo = 1; @(negedge clk); lo = 0;
    idle(200); check_pulses("R8 suspended", 0);
    @(negedge clk); lo = 1; hi = 1; @(negedge clk); lo = 0; hi = 0;
    idle(70); check_pulses("R8 resume", 1);

    // R11: sweep trigger timing across window boundaries with a constant tick
    tag = "R11"; tick_div = 1;
    for (int d = 0; d < 10; d++) begin
      pulse_start(); idle(IGN + 2); pulse_trig(); idle(d); pulse_trig(); idle(d); pulse_trig();
      idle(40); pulses = 0;
    end
    tag = "R10"; pulse_start(); idle(40); check_pulses("R10", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule